// File: doc/BRIEF.md
# NAND Byte Strobe Sequencer

This block drives the write and read strobes of an 8-bit NAND flash data bus. It runs on a clock at twice the system rate, so every timing value is counted in half system cycles, called ticks here. A requester starts a byte write or a byte read with a one-tick request pulse. The block then steps through a fixed sequence of phases. Writes go through a data-drive lead-in, strobe-low and recovery. Reads go through strobe-low and recovery. When recovery ends the block returns a one-tick acknowledge.

Writes and reads each take a two-bit wait code of their own. The code sets the strobe low width, the write data lead time and the recovery time. Both codes are captured when a command is accepted. Read data is taken from the input byte on the last tick of the read strobe low period, and it is presented on the output with the acknowledge.

Top module: `nand_strobe_seq`

## Requirements
- R1: For write wait code 0, 1 and 2, the write strobe is low for exactly 2, 3 and 4 consecutive ticks.
- R2: During a write, the output enable is high and the output byte equals the requested byte for 1, 1 and 2 ticks (codes 0, 1, 2) before the write strobe falls, and for the whole time the strobe is low. The byte is therefore valid 3, 4 or 6 ticks before the strobe rises.
- R3: After the write strobe rises, the output enable and the byte stay driven for 1, 2 and 2 ticks (codes 0, 1, 2). The acknowledge is high in the last of these ticks, and the enable is low in the tick after it.
- R4: For read wait code 0, 1 and 2, the read strobe is low for exactly 3, 4 and 6 consecutive ticks. It falls in the tick right after the request is accepted.
- R5: After the read strobe rises, both strobes stay high for 1, 2 and 2 ticks (codes 0, 1, 2), with the acknowledge high in the last of them. The output enable stays low for the whole read.
- R6: The read result equals the input byte sampled on the clock edge that ends the last low tick of the read strobe. The result is valid while the acknowledge is high and is held until the next read.
- R7: The two strobes are never low in the same tick. Both are high whenever no access is in progress.
- R8: The acknowledge is high for exactly one tick per accepted command. It is never high without an accepted command.
- R9: A request is accepted only when the block is idle. A request pulse that arrives during an access starts no access and changes nothing in the access in progress.
- R10: Wait codes are captured at acceptance. A change to them during an access does not change its timing. Code 3 behaves as code 2.
- R11: Driving the reset input low forces both strobes high and the output enable and acknowledge low at once, without waiting for a clock edge. After the reset is released the block is idle with a zero read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-tick command request pulse |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_wdata | input | 8 | Byte to write |
| wr_wait | input | 2 | Write wait code (3 acts as 2) |
| rd_wait | input | 2 | Read wait code (3 acts as 2) |
| req_ack | output | 1 | One-tick end-of-access acknowledge |
| rd_data | output | 8 | Result of the last read |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dout | output | 8 | Byte driven to the flash data bus |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte returned by the flash |

## Verification
The hardest cases to reach are the ones where the block's own inputs change in the middle of an access. One is a wait code that changes after acceptance. The other is a second request pulse while the block is busy. The driver reaches them by changing the codes, or pulsing the request with the opposite direction and an inverted byte, on the tick right after acceptance. The monitor then checks the phase lengths of the running access against the codes that were captured. It also flags any access for which the driver queued no item. The read sampling point is pinned down by changing the input byte on every low tick of the read strobe, so that only the value present in the last low tick matches the expected result.

// File: rtl/nst_pkg.sv
package nst_pkg;

  localparam int unsigned TICK_W = 3;
  localparam int unsigned MODE_W = 2;

  typedef logic [TICK_W-1:0] tick_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WLOW   = 3'd2,
    ST_WREC   = 3'd3,
    ST_RLOW   = 3'd4,
    ST_RREC   = 3'd5
  } nst_state_e;

  // Phase lengths in ticks (half system cycles), all at least one.
  typedef struct packed {
    tick_t w_pre;
    tick_t w_low;
    tick_t w_rec;
    tick_t r_low;
    tick_t r_rec;
  } nst_timing_t;

  function automatic logic [1:0] clamp_mode(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(2)) ? 2'd2 : m[1:0];
  endfunction

  function automatic nst_timing_t build_timing(input logic [1:0] wm, input logic [1:0] rm);
    nst_timing_t t;
    unique case (wm)
      2'd0:    begin t.w_pre = tick_t'(1); t.w_low = tick_t'(2); t.w_rec = tick_t'(1); end
      2'd1:    begin t.w_pre = tick_t'(1); t.w_low = tick_t'(3); t.w_rec = tick_t'(2); end
      default: begin t.w_pre = tick_t'(2); t.w_low = tick_t'(4); t.w_rec = tick_t'(2); end
    endcase
    unique case (rm)
      2'd0:    begin t.r_low = tick_t'(3); t.r_rec = tick_t'(1); end
      2'd1:    begin t.r_low = tick_t'(4); t.r_rec = tick_t'(2); end
      default: begin t.r_low = tick_t'(6); t.r_rec = tick_t'(2); end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/nst_rst_sync.sv
module nst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/nst_mode_latch.sv
module nst_mode_latch
  import nst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [MODE_W-1:0] rd_mode,
  output nst_timing_t       t_live,
  output nst_timing_t       t_held
);

  localparam int unsigned NCH = 2;

  logic [MODE_W-1:0] mode_in [NCH];
  logic [MODE_W-1:0] mode_q  [NCH];
  logic [1:0]        live_c  [NCH];
  logic [1:0]        held_c  [NCH];

  assign mode_in[0] = wr_mode;
  assign mode_in[1] = rd_mode;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[ch] <= '0;
      end else if (load) begin
        mode_q[ch] <= mode_in[ch];
      end
    end
    assign live_c[ch] = clamp_mode(mode_in[ch]);
    assign held_c[ch] = clamp_mode(mode_q[ch]);
  end

  assign t_live = build_timing(live_c[0], live_c[1]);
  assign t_held = build_timing(held_c[0], held_c[1]);

endmodule

// File: rtl/nst_phase_fsm.sv
module nst_phase_fsm
  import nst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  nst_timing_t t_live,
  input  nst_timing_t t_held,
  output logic        accept,
  output logic        capture,
  output logic        we_n,
  output logic        re_n,
  output logic        doe,
  output logic        ack
);

  nst_state_e st_q, st_d;
  tick_t      cnt_q, cnt_d;
  logic       last;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    last    = (cnt_q == '0);
    capture = (st_q == ST_RLOW) && last;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            st_d  = ST_WSETUP;
            cnt_d = t_live.w_pre - 1'b1;
          end else begin
            st_d  = ST_RLOW;
            cnt_d = t_live.r_low - 1'b1;
          end
        end
      end
      ST_WSETUP: begin
        if (last) begin
          st_d  = ST_WLOW;
          cnt_d = t_held.w_low - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WLOW: begin
        if (last) begin
          st_d  = ST_WREC;
          cnt_d = t_held.w_rec - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RLOW: begin
        if (last) begin
          st_d  = ST_RREC;
          cnt_d = t_held.r_rec - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WREC, ST_RREC: begin
        if (last) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // Strobes and enables are registered from the next state so pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      doe   <= 1'b0;
      ack   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      we_n  <= (st_d != ST_WLOW);
      re_n  <= (st_d != ST_RLOW);
      doe   <= (st_d == ST_WSETUP) || (st_d == ST_WLOW) || (st_d == ST_WREC);
      ack   <= ((st_d == ST_WREC) || (st_d == ST_RREC)) && (cnt_d == '0);
    end
  end

endmodule

// File: rtl/nst_datapath.sv
module nst_datapath #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      rdata <= '0;
    end else begin
      if (load_wr) begin
        dout <= wdata;
      end
      if (capture) begin
        rdata <= din;
      end
    end
  end

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nst_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MODE_W-1:0] wr_wait,
  input  logic [MODE_W-1:0] rd_wait,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_doe,
  input  logic [DATA_W-1:0] nand_din
);

  logic        rst_n_i;
  logic        accept;
  logic        capture;
  nst_timing_t t_live;
  nst_timing_t t_held;

  nst_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  nst_mode_latch u_modes (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load    (accept),
    .wr_mode (wr_wait),
    .rd_mode (rd_wait),
    .t_live  (t_live),
    .t_held  (t_held)
  );

  nst_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .t_live    (t_live),
    .t_held    (t_held),
    .accept    (accept),
    .capture   (capture),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .doe       (nand_doe),
    .ack       (req_ack)
  );

  nst_datapath #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load_wr (accept & req_write),
    .wdata   (req_wdata),
    .capture (capture),
    .din     (nand_din),
    .dout    (nand_dout),
    .rdata   (rd_data)
  );

endmodule

// File: rtl/nst_checker.sv
module nst_checker (
  input logic clk,
  input logic rst_n,
  input logic we_n,
  input logic re_n,
  input logic doe,
  input logic ack
);

  logic [2:0] we_lo;
  logic [2:0] re_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0;
      re_lo <= '0;
    end else begin
      we_lo <= we_n ? 3'd0 : ((we_lo == 3'd7) ? we_lo : we_lo + 3'd1);
      re_lo <= re_n ? 3'd0 : ((re_lo == 3'd7) ? re_lo : re_lo + 3'd1);
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R7
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (we_lo >= 3'd2 && we_lo <= 3'd4)); // R1
  AST_RE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(re_n) |-> (re_lo >= 3'd3 && re_lo <= 3'd6)); // R4
  AST_WE_NEEDS_DOE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> doe); // R2
  AST_READ_NO_DOE: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !doe); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R8
  AST_ACK_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ack |-> (we_n && re_n)); // R3
  AST_DOE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(doe) |-> $past(ack)); // R3

endmodule

bind nand_strobe_seq nst_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .we_n  (nand_we_n),
  .re_n  (nand_re_n),
  .doe   (nand_doe),
  .ack   (req_ack)
);

// File: tb/nand_strobe_seq_tb.sv
module nand_strobe_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [7:0] req_wdata;
  logic [1:0] wr_wait, rd_wait;
  logic       ack;
  logic [7:0] rd_data;
  logic       we_n, re_n, doe;
  logic [7:0] dout, din;

  always #2 clk = ~clk;

  nand_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .wr_wait(wr_wait), .rd_wait(rd_wait),
    .req_ack(ack), .rd_data(rd_data), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_dout(dout), .nand_doe(doe), .nand_din(din)
  );

  int n_chk = 0;
  int n_bad = 0;
  int acks  = 0;

  typedef struct {
    bit         wr;
    logic [7:0] data;
    int         pre;
    int         lo;
    int         rec;
  } item_t;

  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  function automatic item_t make_item(bit wr, logic [7:0] d, logic [1:0] wm, logic [1:0] rm);
    item_t it;
    int m;
    int slow;
    m = wr ? int'(wm) : int'(rm);
    if (m > 2) m = 2;
    slow = (m == 0) ? 3 : (m == 1) ? 4 : 6;
    it.wr   = wr;
    it.data = d;
    it.rec  = (m == 0) ? 1 : 2;
    if (wr) begin
      it.lo  = 2 + m;
      it.pre = slow - it.lo;
    end else begin
      it.lo  = slow;
      it.pre = 0;
    end
    return it;
  endfunction

  // Monitor / scoreboard
  bit    act = 0, ghost = 0, post = 0;
  bit    dout_bad, doe_bad, re_bad;
  item_t cur;
  int    pre, lo, rec;

  always @(negedge clk) begin
    if (!rst_n) begin
      act = 0; ghost = 0; post = 0;
      din = 8'h5A;
    end else begin
      if (post) begin
        chk(we_n && re_n && !doe && !ack, "R3/R7/R8 idle after ack", int'(doe), 0);
        post = 0;
      end
      if (!act && (doe || !we_n || !re_n)) begin
        act = 1; pre = 0; lo = 0; rec = 0;
        dout_bad = 0; doe_bad = 0; re_bad = 0;
        if (exp_q.size() == 0) begin
          ghost = 1;
          chk(0, "R9 access without accepted request", 1, 0);
        end else begin
          cur = exp_q.pop_front();
        end
      end
      if (act && ghost) begin
        if (ack) begin act = 0; ghost = 0; end
      end else if (act) begin
        if (cur.wr) begin
          if (doe && dout !== cur.data) dout_bad = 1;
          if (!re_n) re_bad = 1;
          if (!we_n) lo++;
          else if (lo == 0) pre++;
          else rec++;
        end else begin
          if (doe || !we_n) doe_bad = 1;
          if (!re_n) begin
            lo++;
            din = cur.data ^ 8'(lo);
          end else begin
            rec++;
            din = 8'hC3;
          end
        end
        if (ack) begin
          if (cur.wr) begin
            chk(lo == cur.lo, "R1 write strobe low ticks", lo, cur.lo);
            chk(pre == cur.pre, "R2 data lead ticks", pre, cur.pre);
            chk(!dout_bad, "R2 driven byte", int'(dout), int'(cur.data));
            chk(rec == cur.rec, "R3 write recovery ticks", rec, cur.rec);
            chk(!re_bad, "R7 read strobe during write", 1, 0);
          end else begin
            chk(lo == cur.lo, "R4 read strobe low ticks", lo, cur.lo);
            chk(rec == cur.rec, "R5 read recovery ticks", rec, cur.rec);
            chk(!doe_bad, "R5 enable or write strobe during read", 1, 0);
            chk(rd_data === (cur.data ^ 8'(cur.lo)), "R6 read sample",
                int'(rd_data), int'(cur.data ^ 8'(cur.lo)));
          end
          act = 0;
          post = 1;
          acks++;
        end
      end else if (ack) begin
        chk(0, "R8 acknowledge without access", 1, 0);
      end
    end
  end

  // Driver
  task automatic run_cmd(bit wr, logic [7:0] d, logic [1:0] wm, logic [1:0] rm,
                         bit swap_modes, bit poke);
    int start;
    @(negedge clk);
    start     = acks;
    req_write = wr;
    req_wdata = d;
    wr_wait   = wm;
    rd_wait   = rm;
    req_valid = 1'b1;
    exp_q.push_back(make_item(wr, d, wm, rm));
    @(negedge clk);
    req_valid = 1'b0;
    if (swap_modes) begin  // R10: change codes mid-access
      wr_wait = (wm == 2'd0) ? 2'd2 : 2'd0;
      rd_wait = (rm == 2'd0) ? 2'd2 : 2'd0;
    end
    if (poke) begin        // R9: request while busy
      req_valid = 1'b1;
      req_write = !wr;
      req_wdata = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (acks != start);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    req_valid = 0; req_write = 0; req_wdata = 0; wr_wait = 0; rd_wait = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(we_n && re_n && !doe && !ack, "R11 outputs after reset", int'(doe), 0);
    chk(rd_data == 8'h00, "R11 read result after reset", int'(rd_data), 0);

    // R1 R2 R3: writes in every code, code 3 as 2 (R10)
    run_cmd(1, 8'h3C, 2'd0, 2'd0, 0, 0);
    run_cmd(1, 8'hA1, 2'd1, 2'd0, 0, 0);
    run_cmd(1, 8'h7E, 2'd2, 2'd0, 0, 0);
    run_cmd(1, 8'h81, 2'd3, 2'd0, 0, 0);
    // R4 R5 R6: reads in every code
    run_cmd(0, 8'h10, 2'd0, 2'd0, 0, 0);
    run_cmd(0, 8'h62, 2'd0, 2'd1, 0, 0);
    run_cmd(0, 8'hF0, 2'd0, 2'd2, 0, 0);
    run_cmd(0, 8'h0F, 2'd0, 2'd3, 0, 0);
    // R10: codes change after acceptance
    run_cmd(1, 8'h55, 2'd2, 2'd2, 1, 0);
    run_cmd(0, 8'h99, 2'd0, 2'd0, 1, 0);
    run_cmd(1, 8'h24, 2'd0, 2'd2, 1, 0);
    // R9: request pulses while busy are dropped
    run_cmd(1, 8'hC7, 2'd0, 2'd0, 0, 1);
    run_cmd(0, 8'h4B, 2'd1, 2'd0, 0, 1);
    // back-to-back mixed traffic
    run_cmd(0, 8'h11, 2'd1, 2'd2, 0, 0);
    run_cmd(1, 8'hEE, 2'd1, 2'd2, 0, 0);
    run_cmd(0, 8'h22, 2'd2, 2'd1, 0, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 queued accesses all completed", exp_q.size(), 0);

    // R11: reset in the middle of a write strobe
    @(negedge clk);
    req_write = 1; req_wdata = 8'h6D; wr_wait = 2'd2; req_valid = 1;
    exp_q.push_back(make_item(1, 8'h6D, 2'd2, 2'd0));
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    chk(!we_n, "R11 write strobe low before reset", int'(we_n), 0);
    #1 rst_n = 1'b0;
    #1;
    chk(we_n && re_n && !doe && !ack, "R11 immediate reset of pins", int'(doe), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(we_n && re_n && !doe, "R11 idle after mid-access reset", int'(doe), 0);
    run_cmd(0, 8'h37, 2'd0, 2'd1, 0, 0);
    repeat (5) @(negedge clk);

    report();
    $finish;
  end

endmodule